// File: doc/BRIEF.md
# Programming command frame parser

This block sits behind a serial programmer link and takes in 16-bit command words one per accepted cycle. The first word of every frame is a header that names an operation with a 4-bit opcode and gives the total frame size in words. The parser checks that size against the opcode, and then collects the body words of the frame. From those words it picks out an element count, a 24-bit memory address and, for row writes, the data payload.

For memory commands the parser raises a request toward a non-volatile memory controller and waits for a done pulse from it. The controller does the actual read, erase or program work and is not part of this block. Every frame ends with a two-word response. The first word gives a status, echoes the opcode and carries a byte that holds either query data or an error code. The second word gives the length of the response.

The parser never times out. Word gaps of any length on the link and memory operations of any duration leave the result unchanged.

Top module: `cfp_parser`

## Requirements
- R1: Reset leaves `ready_o` high and `rsp_valid_o`, `rsp_last_o`, `mem_req_o` and `mem_wvalid_o` low. A word is taken only in a cycle where `word_valid_i` and `ready_o` are both high. In the header, bits 15:12 are the opcode and bits 11:0 are the frame length in words, with the header counted.
- R2: Opcode 0h with length 1 is a sanity check. Its response has status pass, query byte 00h, and no memory request is raised.
- R3: Opcode Bh with length 1 is a version query. Its response has status pass and carries the `VERSION` parameter in the query byte, and no memory request is raised.
- R4: Opcode 2h with length 4 is a program-memory read. Word 1 is the count N. Word 2 holds address bits 23:16 in its bits 7:0, and its upper byte is ignored. Word 3 holds address bits 15:0. When 1 ≤ N ≤ 32768, a request is raised with `mem_op_o`=0, the 24-bit address on `mem_addr_o` and N on `mem_count_o`.
- R5: A read with N = 0 or N > 32768 gets status fail and query byte 01h, and no memory request is raised.
- R6: Opcode 5h with length 33h is a row write. Word 1 carries address bits 23:16 in its bits 7:0 and word 2 carries address bits 15:0. Words 3 to 50 are 48 data words. Each data word shows on `mem_wdata_o` with a one-cycle `mem_wvalid_o` in the cycle after it is taken, with `mem_widx_o` counting 0 to 47. After the last data word a request is raised with `mem_op_o`=1 and `mem_count_o`=32.
- R7: `mem_req_o` and its address, count and op stay steady until a cycle with `mem_done_i` high. If `mem_ok_i`=1 in that cycle, the status is pass with query byte 00h. Otherwise the status is fail with query byte 02h.
- R8: An unknown opcode, or a length that differs from the one its opcode requires, gets status not-acknowledged and query byte 03h. No memory request is raised and no body words are consumed, so the next word taken is decoded as a header.
- R9: The response is two words on back-to-back cycles with `rsp_valid_o` high. Word 0 is {status[15:12], opcode echo[11:8], query byte[7:0]}, where pass is 1h, fail is 2h and not-acknowledged is 3h. Word 1 is 0002h and comes with `rsp_last_o`. From the cycle after the final word of a frame is taken until the last response word has gone out, `ready_o` is low, and words offered in that window have no effect.
- R10: Idle cycles between words and any delay of `mem_done_i` leave the decoded fields and the response unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Command word present |
| word_i | input | 16 | Command word |
| ready_o | output | 1 | Parser can take a word this cycle |
| mem_req_o | output | 1 | Memory operation requested |
| mem_op_o | output | 1 | 0 = read, 1 = row write |
| mem_addr_o | output | 24 | Memory address |
| mem_count_o | output | 16 | Element count of the operation |
| mem_wvalid_o | output | 1 | Payload word strobe |
| mem_wdata_o | output | 16 | Payload word |
| mem_widx_o | output | 6 | Payload word index in the row |
| mem_done_i | input | 1 | Memory operation finished |
| mem_ok_i | input | 1 | Memory operation succeeded (sampled with done) |
| rsp_valid_o | output | 1 | Response word present |
| rsp_word_o | output | 16 | Response word |
| rsp_last_o | output | 1 | Final response word |

## Verification
Two kinds of event can fall in the same cycle. First, `mem_done_i` can arrive in the very first cycle of a request, in the same cycle the request rises. Second, the programmer can offer a new header while the response is still going out. The bench provokes the first case by setting the memory model's delay to zero. It then checks that the status reflects `mem_ok_i` from that single cycle and that the request count grows by exactly one. For the second case it holds a version-query header on the link throughout a sanity-check response. That response must carry the sanity-check opcode, and no second response may appear afterwards.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;

  localparam logic [3:0] OP_SCHECK = 4'h0;
  localparam logic [3:0] OP_READP  = 4'h2;
  localparam logic [3:0] OP_PROGP  = 4'h5;
  localparam logic [3:0] OP_QVER   = 4'hB;

  localparam logic [3:0] RS_PASS = 4'h1;
  localparam logic [3:0] RS_FAIL = 4'h2;
  localparam logic [3:0] RS_NACK = 4'h3;

  localparam logic [7:0] QE_NONE    = 8'h00;
  localparam logic [7:0] QE_COUNT   = 8'h01;
  localparam logic [7:0] QE_MEM     = 8'h02;
  localparam logic [7:0] QE_ILLEGAL = 8'h03;

  localparam logic [WORD_W-1:0] RSP_LEN = 16'h0002;

  typedef enum logic [2:0] {
    S_HDR, S_BODY, S_REQ, S_RSP0, S_RSP1
  } fsm_e;
endpackage

// File: rtl/cfp_hdr_decode.sv
module cfp_hdr_decode
  import cfp_pkg::*;
#(
  parameter int ROW_WORDS = 48
) (
  input  logic [WORD_W-1:0] hdr_i,
  output logic [3:0]        op_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              legal_o
);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_READ = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_PROG = LEN_W'(3 + ROW_WORDS);

  logic [LEN_W-1:0] want_len;
  logic             known;

  assign op_o  = hdr_i[15:12];
  assign len_o = hdr_i[LEN_W-1:0];

  always_comb begin
    known    = 1'b1;
    want_len = LEN_ONE;
    case (op_o)
      OP_SCHECK: want_len = LEN_ONE;
      OP_QVER:   want_len = LEN_ONE;
      OP_READP:  want_len = LEN_READ;
      OP_PROGP:  want_len = LEN_PROG;
      default:   known = 1'b0;
    endcase
  end

  assign legal_o = known && (len_o == want_len);
endmodule

// File: rtl/cfp_field_capture.sv
module cfp_field_capture
  import cfp_pkg::*;
#(
  parameter int ROW_WORDS = 48,
  localparam int WIDX_W = $clog2(ROW_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [3:0]        op_i,
  input  logic [LEN_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wvalid_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [WIDX_W-1:0] widx_o
);
  // body word positions of the address halves per opcode
  logic [LEN_W-1:0] msb_pos, lsw_pos;

  always_comb begin
    if (op_i == OP_READP) begin
      msb_pos = LEN_W'(2);
      lsw_pos = LEN_W'(3);
    end else begin
      msb_pos = LEN_W'(1);
      lsw_pos = LEN_W'(2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o  <= '0;
      addr_o   <= '0;
      wvalid_o <= 1'b0;
      wdata_o  <= '0;
      widx_o   <= '0;
    end else begin
      wvalid_o <= 1'b0;
      if (take_i) begin
        if (op_i == OP_READP && idx_i == LEN_W'(1)) count_o <= word_i;
        if (idx_i == msb_pos) addr_o[23:16] <= word_i[7:0];
        if (idx_i == lsw_pos) addr_o[15:0]  <= word_i;
        if (op_i == OP_PROGP && idx_i >= LEN_W'(3)) begin
          wvalid_o <= 1'b1;
          wdata_o  <= word_i;
          widx_o   <= WIDX_W'(idx_i - LEN_W'(3));
        end
      end
    end
  end
endmodule

// File: rtl/cfp_rsp_builder.sv
module cfp_rsp_builder
  import cfp_pkg::*;
(
  input  fsm_e              state_i,
  input  logic [3:0]        status_i,
  input  logic [3:0]        op_i,
  input  logic [7:0]        qe_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  always_comb begin
    valid_o = 1'b0;
    last_o  = 1'b0;
    word_o  = '0;
    case (state_i)
      S_RSP0: begin
        valid_o = 1'b1;
        word_o  = {status_i, op_i, qe_i};
      end
      S_RSP1: begin
        valid_o = 1'b1;
        last_o  = 1'b1;
        word_o  = RSP_LEN;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfp_parser.sv
module cfp_parser
  import cfp_pkg::*;
#(
  parameter logic [7:0] VERSION   = 8'h15,
  parameter int         ROW_WORDS = 48,
  parameter int         MAX_READ  = 32768,
  localparam int        WIDX_W    = $clog2(ROW_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [15:0]       word_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic              mem_op_o,
  output logic [23:0]       mem_addr_o,
  output logic [15:0]       mem_count_o,
  output logic              mem_wvalid_o,
  output logic [15:0]       mem_wdata_o,
  output logic [WIDX_W-1:0] mem_widx_o,
  input  logic              mem_done_i,
  input  logic              mem_ok_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_word_o,
  output logic              rsp_last_o
);
  localparam int ROW_INSTR = (ROW_WORDS * 2) / 3;

  fsm_e             state_q;
  logic [3:0]       op_q, status_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [7:0]       qe_q;

  logic [3:0]       dec_op;
  logic [LEN_W-1:0] dec_len;
  logic             dec_legal;
  logic [CNT_W-1:0] cap_count;
  logic             body_take, body_last, count_bad;

  cfp_hdr_decode #(.ROW_WORDS(ROW_WORDS)) u_dec (
    .hdr_i   (word_i),
    .op_o    (dec_op),
    .len_o   (dec_len),
    .legal_o (dec_legal)
  );

  assign ready_o   = (state_q == S_HDR) || (state_q == S_BODY);
  assign body_take = (state_q == S_BODY) && word_valid_i;
  assign body_last = (idx_q == len_q - LEN_W'(1));
  assign count_bad = (cap_count == '0) || (32'(cap_count) > MAX_READ);

  cfp_field_capture #(.ROW_WORDS(ROW_WORDS)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (body_take),
    .op_i     (op_q),
    .idx_i    (idx_q),
    .word_i   (word_i),
    .count_o  (cap_count),
    .addr_o   (mem_addr_o),
    .wvalid_o (mem_wvalid_o),
    .wdata_o  (mem_wdata_o),
    .widx_o   (mem_widx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_HDR;
      op_q     <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      status_q <= '0;
      qe_q     <= '0;
    end else begin
      case (state_q)
        S_HDR: if (word_valid_i) begin
          op_q  <= dec_op;
          len_q <= dec_len;
          idx_q <= LEN_W'(1);
          if (!dec_legal) begin
            status_q <= RS_NACK;
            qe_q     <= QE_ILLEGAL;
            state_q  <= S_RSP0;
          end else if (dec_len == LEN_W'(1)) begin
            status_q <= RS_PASS;
            qe_q     <= (dec_op == OP_QVER) ? VERSION : QE_NONE;
            state_q  <= S_RSP0;
          end else begin
            state_q  <= S_BODY;
          end
        end
        S_BODY: if (word_valid_i) begin
          idx_q <= idx_q + LEN_W'(1);
          if (body_last) begin
            // read count was captured two words earlier
            if (op_q == OP_READP && count_bad) begin
              status_q <= RS_FAIL;
              qe_q     <= QE_COUNT;
              state_q  <= S_RSP0;
            end else begin
              state_q  <= S_REQ;
            end
          end
        end
        S_REQ: if (mem_done_i) begin
          status_q <= mem_ok_i ? RS_PASS : RS_FAIL;
          qe_q     <= mem_ok_i ? QE_NONE : QE_MEM;
          state_q  <= S_RSP0;
        end
        S_RSP0:  state_q <= S_RSP1;
        S_RSP1:  state_q <= S_HDR;
        default: state_q <= S_HDR;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_REQ);
  assign mem_op_o    = (op_q == OP_PROGP);
  assign mem_count_o = (op_q == OP_READP) ? cap_count : CNT_W'(ROW_INSTR);

  cfp_rsp_builder u_rsp (
    .state_i  (state_q),
    .status_i (status_q),
    .op_i     (op_q),
    .qe_i     (qe_q),
    .valid_o  (rsp_valid_o),
    .word_o   (rsp_word_o),
    .last_o   (rsp_last_o)
  );
endmodule

// File: rtl/cfp_parser_chk.sv
module cfp_parser_chk #(
  parameter int ROW_WORDS = 48,
  localparam int WIDX_W = $clog2(ROW_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_op_o,
  input logic [23:0]       mem_addr_o,
  input logic [15:0]       mem_count_o,
  input logic              mem_wvalid_o,
  input logic [WIDX_W-1:0] mem_widx_o,
  input logic              mem_done_i,
  input logic              rsp_valid_o,
  input logic [15:0]       rsp_word_o,
  input logic              rsp_last_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_done_i |=> mem_req_o) else $error("req dropped"); // R7
  AST_REQ_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_done_i |=> $stable(mem_addr_o) && $stable(mem_count_o) && $stable(mem_op_o))
    else $error("req fields moved"); // R7
  AST_DONE_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_done_i |=> rsp_valid_o && !rsp_last_o && !mem_req_o)
    else $error("no response after done"); // R7
  AST_RSP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_last_o |=> rsp_valid_o && rsp_last_o && rsp_word_o == 16'h0002)
    else $error("response pair broken"); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !ready_o) else $error("ready while busy"); // R9
  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_last_o |-> rsp_word_o[15:12] inside {4'h1, 4'h2, 4'h3})
    else $error("bad status"); // R9
  AST_NACK_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_last_o && rsp_word_o[15:12] == 4'h3 |-> !$past(mem_req_o))
    else $error("nack after request"); // R8
  AST_WIDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wvalid_o |-> 32'(mem_widx_o) < ROW_WORDS) else $error("widx range"); // R6
endmodule

bind cfp_parser cfp_parser_chk #(.ROW_WORDS(ROW_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .mem_req_o    (mem_req_o),
  .mem_op_o     (mem_op_o),
  .mem_addr_o   (mem_addr_o),
  .mem_count_o  (mem_count_o),
  .mem_wvalid_o (mem_wvalid_o),
  .mem_widx_o   (mem_widx_o),
  .mem_done_i   (mem_done_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_word_o   (rsp_word_o),
  .rsp_last_o   (rsp_last_o)
);

// File: tb/cfp_parser_tb.sv
`timescale 1ns/1ps
module cfp_parser_tb;
  localparam logic [7:0] VER = 8'h15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [15:0] word = '0;
  logic ready, mem_req, mem_op, mem_wvalid, rsp_valid, rsp_last;
  logic [23:0] mem_addr;
  logic [15:0] mem_count, mem_wdata, rsp_word;
  logic [5:0]  mem_widx;
  logic mem_done = 1'b0, mem_ok = 1'b0;

  int errors = 0, checks = 0;
  int req_cnt = 0, wcount = 0;
  int mem_dly = 0, dly_cnt = 0, gap_max = 0;
  bit ok_cfg = 1'b1, req_seen = 1'b0;
  logic        r_op;
  logic [23:0] r_addr;
  logic [15:0] r_count;
  logic [15:0] got_data [48];
  logic [15:0] exp_data [48];

  always #4 clk = ~clk;

  cfp_parser #(.VERSION(VER)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .word_i(word),
    .ready_o(ready), .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_addr_o(mem_addr),
    .mem_count_o(mem_count), .mem_wvalid_o(mem_wvalid), .mem_wdata_o(mem_wdata),
    .mem_widx_o(mem_widx), .mem_done_i(mem_done), .mem_ok_i(mem_ok),
    .rsp_valid_o(rsp_valid), .rsp_word_o(rsp_word), .rsp_last_o(rsp_last)
  );

  // memory model and request / payload monitor
  always @(negedge clk) begin
    if (mem_wvalid) begin
      got_data[mem_widx] = mem_wdata;
      wcount++;
    end
    if (mem_req) begin
      if (!req_seen) begin
        req_seen = 1'b1; req_cnt++;
        r_op = mem_op; r_addr = mem_addr; r_count = mem_count;
      end
      mem_ok   = ok_cfg;
      mem_done = (dly_cnt >= mem_dly);
      dly_cnt++;
    end else begin
      req_seen = 1'b0; mem_done = 1'b0; dly_cnt = 0;
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    int g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
    repeat (g) @(negedge clk);
    @(negedge clk);
    while (!ready) @(negedge clk);
    word_valid = 1'b1; word = w;
    @(posedge clk); #1;
    word_valid = 1'b0;
  endtask

  task automatic get_rsp(output logic [15:0] w0, output logic [15:0] w1, output bit last_ok);
    int n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    w0 = rsp_word; last_ok = !rsp_last;
    @(negedge clk);
    w1 = rsp_word; last_ok = last_ok && rsp_valid && rsp_last;
  endtask

  function automatic logic [15:0] exp_w0(input logic [3:0] op, input logic [11:0] len,
                                         input logic [15:0] n, input bit ok);
    logic [11:0] want;
    bit known = 1'b1;
    case (op)
      4'h0, 4'hB: want = 12'd1;
      4'h2:       want = 12'd4;
      4'h5:       want = 12'h033;
      default:  begin known = 1'b0; want = 12'd0; end
    endcase
    if (!known || len != want) return {4'h3, op, 8'h03};
    if (op == 4'hB) return {4'h1, op, VER};
    if (op == 4'h0) return {4'h1, op, 8'h00};
    if (op == 4'h2 && (n == 0 || n > 16'd32768)) return {4'h2, op, 8'h01};
    return ok ? {4'h1, op, 8'h00} : {4'h2, op, 8'h02};
  endfunction

  task automatic frame(input logic [3:0] op, input logic [11:0] len, input logic [15:0] n,
                       input logic [23:0] addr, input bit ok, input int dly, input string tag);
    logic [15:0] w0, w1, e0;
    bit lok, legal, want_req;
    int rc0 = req_cnt;
    ok_cfg = ok; mem_dly = dly; wcount = 0;
    e0 = exp_w0(op, len, n, ok);
    legal = (e0[15:12] != 4'h3);
    want_req = legal && (op == 4'h2 || op == 4'h5) && e0[7:0] != 8'h01;
    send({op, len});
    if (legal && op == 4'h2) begin
      send(n); send({8'($urandom), addr[23:16]}); send(addr[15:0]);
    end else if (legal && op == 4'h5) begin
      send({8'($urandom), addr[23:16]}); send(addr[15:0]);
      for (int i = 0; i < 48; i++) begin
        exp_data[i] = 16'($urandom);
        send(exp_data[i]);
      end
    end
    get_rsp(w0, w1, lok);
    check(w0 == e0, {tag, " R9 word0"}, w0, e0);
    check(w1 == 16'h0002 && lok, {tag, " R9 word1/last"}, w1, 16'h0002);
    if (want_req) begin
      check(req_cnt == rc0 + 1, {tag, " R7 one request"}, req_cnt - rc0, 1);
      check(r_addr == addr, {tag, " R4 R6 address"}, r_addr, addr);
      if (op == 4'h2) begin
        check(r_op == 1'b0 && r_count == n, {tag, " R4 read count/op"}, {r_op, r_count}, {1'b0, n});
      end else begin
        check(r_op == 1'b1 && r_count == 16'd32, {tag, " R6 row count/op"}, {r_op, r_count}, {1'b1, 16'd32});
        check(wcount == 48, {tag, " R6 payload strobes"}, wcount, 48);
        for (int i = 0; i < 48; i++)
          check(got_data[i] == exp_data[i], {tag, " R6 payload word"}, got_data[i], exp_data[i]);
      end
    end else begin
      check(req_cnt == rc0, {tag, " R2 R3 R5 R8 no request"}, req_cnt - rc0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] w0, w1;
    bit lok;
    void'($urandom(32'd7741));
    #1;
    check(ready && !rsp_valid && !rsp_last && !mem_req && !mem_wvalid, "R1 reset state",
          {ready, rsp_valid, rsp_last, mem_req, mem_wvalid}, 5'b10000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    frame(4'h0, 12'd1, 0, 0, 1, 0, "sanity R2");
    frame(4'hB, 12'd1, 0, 0, 1, 0, "version R3");
    frame(4'h2, 12'd4, 16'd1, 24'h01_2345, 1, 0, "read N=1 R4");
    frame(4'h2, 12'd4, 16'd32768, 24'hAB_CDEF, 1, 2, "read N=max R4");
    frame(4'h2, 12'd4, 16'd0, 24'h00_0010, 1, 0, "read N=0 R5");
    frame(4'h2, 12'd4, 16'd32769, 24'h00_0010, 1, 0, "read N=max+1 R5");
    frame(4'h2, 12'd4, 16'hFFFF, 24'h00_0010, 1, 0, "read N=ffff R5");
    frame(4'h5, 12'h033, 0, 24'h00_1200, 1, 0, "row R6");
    frame(4'h5, 12'h033, 0, 24'h7F_FF80, 0, 0, "row done-first-cycle fail R7");
    frame(4'h2, 12'd4, 16'd9, 24'h00_0400, 0, 40, "read slow fail R10");
    frame(4'h7, 12'd1, 0, 0, 1, 0, "bad opcode R8");
    frame(4'h0, 12'd2, 0, 0, 1, 0, "bad length R8");
    frame(4'h2, 12'd5, 0, 0, 1, 0, "read bad length R8");
    frame(4'h5, 12'h032, 0, 0, 1, 0, "row bad length R8");
    frame(4'hB, 12'd0, 0, 0, 1, 0, "zero length R8");
    frame(4'h0, 12'd1, 0, 0, 1, 0, "header after nack R8");

    // header offered while the response is out must be ignored (R9)
    send(16'h0001);
    word_valid = 1'b1; word = 16'hB001;
    get_rsp(w0, w1, lok);
    word_valid = 1'b0;
    check(w0 == 16'h1000, "R9 busy-word ignored, word0", w0, 16'h1000);
    begin
      bit extra = 1'b0;
      repeat (6) begin @(negedge clk); if (rsp_valid) extra = 1'b1; end
      check(!extra && ready, "R9 no response from ignored word", extra, 0);
    end

    gap_max = 3;
    for (int k = 0; k < 120; k++) begin
      int sel = int'($urandom_range(9, 0));
      logic [3:0] op; logic [11:0] len; logic [15:0] n;
      case (sel)
        0, 1: begin op = 4'h0; len = 12'd1; end
        2:    begin op = 4'hB; len = 12'd1; end
        3, 4, 5: begin op = 4'h2; len = 12'd4; end
        6, 7: begin op = 4'h5; len = 12'h033; end
        default: begin op = 4'($urandom); len = 12'($urandom_range(6, 0)); end
      endcase
      n = ($urandom_range(3, 0) == 0) ? 16'($urandom) : 16'($urandom_range(32768, 1));
      frame(op, len, n, 24'($urandom), 1'($urandom), int'($urandom_range(5, 0)), "random R10");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule